// File: doc/BRIEF.md
# Serial Flash Identification Responder

This block is the slave-side command front end of a serial NOR flash. It answers the identification instructions and guards writes to the status register. The serial lines are sampled in the system clock domain. The block finds the edges of the serial clock itself and assembles each eight-clock bus cycle, most significant bit first. The first bus cycle after chip select falls is always the opcode.

Three kinds of reply are produced. The three-byte JEDEC identity is sent once, and after it the data line is released. The manufacturer/device pair repeats until chip select rises, and bit 0 of the third address byte chooses which of the two bytes comes first. The status-read reply repeats the status byte for as long as clocks arrive. A status write takes effect only when the instruction just before it was the write-enable instruction. A successful write clears the write-enable latch. Array read, program and erase are not part of this block.

The serial data output is a value plus an enable. When the enable is low, the pad is left in high impedance.

Top module: `flash_id_responder`

## Requirements
- R1: After reset so_oe is 0, wr_latch is 0 and stat_reg is 00h.
- R2: While the opcode byte (the first eight rising SCK edges after cs_n falls) is being received, so_oe stays 0.
- R3: Opcode 9Fh returns the bytes 8Ch, 41h, 16h in that order, MSB first. The data changes after falling SCK and is valid at each rising SCK.
- R4: Once the three bytes of 9Fh have been sent, so_oe is 0 for any further SCK cycles.
- R5: Opcode 90h followed by three address bytes whose last byte has bit 0 = 0 returns 8Ch, 15h, 8Ch, 15h, … without end.
- R6: Opcode 90h with bit 0 of the last address byte = 1 returns 15h, 8Ch, 15h, 8Ch, … without end.
- R7: Opcode 05h returns stat_reg repeatedly for as long as SCK runs.
- R8: Opcode 06h sets wr_latch. If the next instruction is 01h, its data byte is loaded into stat_reg and wr_latch clears.
- R9: An 01h instruction that was not directly preceded by 06h leaves stat_reg unchanged.
- R10: Any opcode other than 01h or 06h clears wr_latch, so a later 01h is ignored.
- R11: When cs_n is high, so_oe is 0 and the bit counter and command state restart. A partial byte that is cut off by cs_n rising has no effect on the next instruction.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial lines are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host (mode 0) |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so_d | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out enable; 0 means high impedance |
| wr_latch | output | 1 | Write-enable latch |
| stat_reg | output | 8 | Status register contents |

## Verification
Each serial line passes through one sampling flop and one edge-detect flop. Because of this, a decoded opcode or a status write shows up about two system clocks after the rising SCK edge that completes it. A new output bit appears about two clocks after the falling SCK edge. The host model in the bench holds each SCK level for four system clocks and samples so_d and so_oe just before it raises SCK. That is where a real host samples, and it is well past the two-clock latency. The latch and status ports are checked only after chip select has been high for several clocks. Expected reply bytes are pushed into a queue by the driver and popped as each byte is assembled.

// File: rtl/flashid_pkg.sv
// Package flashid_pkg: shared widths, opcodes and the command-state type
// for the identification responder. Nothing in here holds state.
package flashid_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_JEDEC_ID = 8'h9F;
    localparam logic [BYTE_W-1:0] OP_PAIR_ID  = 8'h90;
    localparam logic [BYTE_W-1:0] OP_RD_STAT  = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WR_EN    = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WR_STAT  = 8'h01;

    typedef enum logic [2:0] {
        M_OPCODE,   // receiving the opcode byte
        M_ADDR,     // receiving address bytes of the pair-ID command
        M_JEDEC,    // sending the three identity bytes
        M_PAIR,     // sending manufacturer/device pair forever
        M_STAT,     // sending status byte forever
        M_WDATA,    // receiving status-write data byte
        M_IDLE      // nothing more to do until chip select rises
    } cmd_mode_t;
endpackage

// File: rtl/flashid_sync.sv
// Module flashid_sync: samples the serial lines into the system clock
// domain and produces one-cycle SCK rise/fall strobes.
// Assumes the system clock is at least four times faster than SCK and that
// SI is stable around the rising SCK edge.
module flashid_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_idle,
    output logic si_s
);
    logic sck_d1, sck_d2, cs_d1, si_d1;

    // Sampling and edge-history flops for the serial lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d1 <= 1'b0;
            sck_d2 <= 1'b0;
            cs_d1  <= 1'b1;
            si_d1  <= 1'b0;
        end else begin
            sck_d1 <= sck;
            sck_d2 <= sck_d1;
            cs_d1  <= cs_n;
            si_d1  <= si;
        end
    end

    // Edge strobes and aligned sampled data.
    always_comb begin
        sck_rise = sck_d1 & ~sck_d2 & ~cs_d1;
        sck_fall = ~sck_d1 & sck_d2 & ~cs_d1;
        cs_idle  = cs_d1;
        si_s     = si_d1;
    end
endmodule

// File: rtl/flashid_cmd.sv
// Module flashid_cmd: assembles bus cycles from SI, decodes the opcode,
// walks the address bytes of the pair-ID command and owns the write-enable
// latch and the status register.
// Assumes strobes from flashid_sync; cs_idle restarts every instruction.
module flashid_cmd
    import flashid_pkg::*;
#(
    parameter int ADDR_BYTES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              cs_idle,
    input  logic              si_s,
    output cmd_mode_t         mode,
    output logic              pair_swap,
    output logic [BYTE_W-1:0] stat_q,
    output logic              wel
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam int AB_W  = $clog2(ADDR_BYTES + 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(BYTE_W - 1);
    localparam logic [AB_W-1:0]  LAST_ADDR = AB_W'(ADDR_BYTES - 1);

    logic [BIT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] shreg;
    logic [AB_W-1:0]   addr_cnt;
    logic [BYTE_W-1:0] rx_byte;
    logic              byte_done;

    // Completed byte including the bit arriving on this edge.
    always_comb begin
        rx_byte   = {shreg, si_s};
        byte_done = sck_rise && (bit_cnt == LAST_BIT);
    end

    // Bit counting, opcode decode, address walk, latch and status update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            addr_cnt  <= '0;
            mode      <= M_OPCODE;
            pair_swap <= 1'b0;
            stat_q    <= '0;
            wel       <= 1'b0;
        end else if (cs_idle) begin
            bit_cnt  <= '0;
            addr_cnt <= '0;
            mode     <= M_OPCODE;
        end else if (sck_rise) begin
            shreg   <= rx_byte[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (byte_done) begin
                case (mode)
                    M_OPCODE: begin
                        case (rx_byte)
                            OP_JEDEC_ID: begin mode <= M_JEDEC; wel <= 1'b0; end
                            OP_PAIR_ID:  begin mode <= M_ADDR;  wel <= 1'b0; end
                            OP_RD_STAT:  begin mode <= M_STAT;  wel <= 1'b0; end
                            OP_WR_EN:    begin mode <= M_IDLE;  wel <= 1'b1; end
                            OP_WR_STAT:  mode <= M_WDATA;
                            default:     begin mode <= M_IDLE;  wel <= 1'b0; end
                        endcase
                    end
                    M_ADDR: begin
                        addr_cnt <= addr_cnt + 1'b1;
                        if (addr_cnt == LAST_ADDR) begin
                            pair_swap <= rx_byte[0];
                            mode      <= M_PAIR;
                        end
                    end
                    M_WDATA: begin
                        if (wel) begin
                            stat_q <= rx_byte;
                            wel    <= 1'b0;
                        end
                        mode <= M_IDLE;
                    end
                    default: mode <= mode;
                endcase
            end
        end
    end

    // R8
    stat_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q != $past(stat_q)) |-> ($past(wel) && !wel));

    // R10
    latch_set_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(sck_rise));

    // R11
    idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> (mode == M_OPCODE));
endmodule

// File: rtl/flashid_tx.sv
// Module flashid_tx: serialises the reply bytes on falling SCK, MSB first,
// and controls the output enable. The identity reply stops after its third
// byte; the pair and status replies run until chip select rises.
// Assumes mode from flashid_cmd changes only on rising SCK or cs_idle.
module flashid_tx
    import flashid_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MFR_ID   = 8'h8C,
    parameter logic [BYTE_W-1:0] MEM_TYPE = 8'h41,
    parameter logic [BYTE_W-1:0] CAPACITY = 8'h16,
    parameter logic [BYTE_W-1:0] DEV_ID   = 8'h15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_fall,
    input  logic              cs_idle,
    input  cmd_mode_t         mode,
    input  logic              pair_swap,
    input  logic [BYTE_W-1:0] stat_q,
    output logic              so_d,
    output logic              so_oe
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    logic [BIT_W-1:0]  tx_bit;
    logic [1:0]        tx_idx;
    logic [BYTE_W-1:0] cur_byte;
    logic              sending;

    // Choose the byte currently on the wire and whether output is due.
    always_comb begin
        cur_byte = '0;
        sending  = 1'b0;
        case (mode)
            M_JEDEC: begin
                sending = (tx_idx != 2'd3);
                case (tx_idx)
                    2'd0:    cur_byte = MFR_ID;
                    2'd1:    cur_byte = MEM_TYPE;
                    default: cur_byte = CAPACITY;
                endcase
            end
            M_PAIR: begin
                sending  = 1'b1;
                cur_byte = (tx_idx[0] ^ pair_swap) ? DEV_ID : MFR_ID;
            end
            M_STAT: begin
                sending  = 1'b1;
                cur_byte = stat_q;
            end
            default: ;
        endcase
    end

    // Shift out one bit per falling SCK; release the line when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit <= '0;
            tx_idx <= '0;
            so_d   <= 1'b0;
            so_oe  <= 1'b0;
        end else if (cs_idle) begin
            tx_bit <= '0;
            tx_idx <= '0;
            so_oe  <= 1'b0;
        end else if (sck_fall) begin
            if (sending) begin
                so_d   <= cur_byte[LAST_BIT - tx_bit];
                so_oe  <= 1'b1;
                tx_bit <= tx_bit + 1'b1;
                if (tx_bit == LAST_BIT)
                    tx_idx <= tx_idx + 1'b1;
            end else begin
                so_oe <= 1'b0;
            end
        end
    end

    // R2
    quiet_in_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_OPCODE) |-> !so_oe);

    // R11
    release_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> !so_oe);

    // R4
    jedec_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_JEDEC && tx_idx == 2'd3 && sck_fall) |=> !so_oe);
endmodule

// File: rtl/flash_id_responder.sv
// Module flash_id_responder: top of the serial-flash identification front
// end. Ties together line sampling, command decode and reply serialiser.
// Assumes SPI mode 0 and a system clock at least four times SCK.
module flash_id_responder
    import flashid_pkg::*;
#(
    parameter int                ADDR_BYTES = 3,
    parameter logic [BYTE_W-1:0] MFR_ID     = 8'h8C,
    parameter logic [BYTE_W-1:0] MEM_TYPE   = 8'h41,
    parameter logic [BYTE_W-1:0] CAPACITY   = 8'h16,
    parameter logic [BYTE_W-1:0] DEV_ID     = 8'h15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              so_d,
    output logic              so_oe,
    output logic              wr_latch,
    output logic [BYTE_W-1:0] stat_reg
);
    logic      sck_rise, sck_fall, cs_idle, si_s;
    logic      pair_swap;
    cmd_mode_t mode;

    flashid_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_idle(cs_idle), .si_s(si_s)
    );

    flashid_cmd #(.ADDR_BYTES(ADDR_BYTES)) u_cmd (
        .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .cs_idle(cs_idle),
        .si_s(si_s), .mode(mode), .pair_swap(pair_swap),
        .stat_q(stat_reg), .wel(wr_latch)
    );

    flashid_tx #(
        .MFR_ID(MFR_ID), .MEM_TYPE(MEM_TYPE), .CAPACITY(CAPACITY), .DEV_ID(DEV_ID)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall), .cs_idle(cs_idle),
        .mode(mode), .pair_swap(pair_swap), .stat_q(stat_reg),
        .so_d(so_d), .so_oe(so_oe)
    );
endmodule

// File: tb/flash_id_responder_tb.sv
module flash_id_responder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       si = 1'b0;
    logic       so_d, so_oe, wr_latch;
    logic [7:0] stat_reg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      req_q[$];

    always #2.5 clk = ~clk;

    flash_id_responder u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so_d(so_d), .so_oe(so_oe), .wr_latch(wr_latch), .stat_reg(stat_reg)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cs_low();
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // One bus cycle: drive mosi, collect miso sampled just before rising SCK.
    task automatic xfer(input logic [7:0] mosi, output logic [7:0] miso,
                        output bit oe_all, output bit oe_any);
        oe_all = 1'b1;
        oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            si = mosi[i];
            repeat (4) @(negedge clk);
            miso[i] = so_d;
            oe_all  = oe_all & so_oe;
            oe_any  = oe_any | so_oe;
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    // Driver side of the scoreboard: queue an expected reply byte.
    task automatic expect_byte(input logic [7:0] b, input string req);
        exp_q.push_back(b);
        req_q.push_back(req);
    endtask

    // Monitor side: clock out queued bytes and compare as they arrive.
    task automatic drain();
        logic [7:0] got;
        bit all, any;
        while (exp_q.size() > 0) begin
            logic [7:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            xfer(8'h00, got, all, any);
            check(all && got == e, r, got, e);
        end
    endtask

    task automatic send_op(input logic [7:0] op);
        logic [7:0] got;
        bit all, any;
        xfer(op, got, all, any);
        check(!any, "R2", any, 0);
    endtask

    task automatic send_data(input logic [7:0] b);
        logic [7:0] got;
        bit all, any;
        xfer(b, got, all, any);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        bit all, any;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!so_oe, "R1", so_oe, 0);
        check(!wr_latch, "R1", wr_latch, 0);
        check(stat_reg == 8'h00, "R1", stat_reg, 0);

        // R3 / R4 JEDEC identity then released line
        cs_low();
        send_op(8'h9F);
        expect_byte(8'h8C, "R3");
        expect_byte(8'h41, "R3");
        expect_byte(8'h16, "R3");
        drain();
        xfer(8'h00, got, all, any);
        check(!any, "R4", any, 0);
        xfer(8'h00, got, all, any);
        check(!any, "R4", any, 0);
        cs_high();
        // R11 released while deselected
        check(!so_oe, "R11", so_oe, 0);

        // R5 pair, bit0 = 0
        cs_low();
        send_op(8'h90);
        send_data(8'hFF); send_data(8'hFF); send_data(8'hFE);
        for (int k = 0; k < 3; k++) begin
            expect_byte(8'h8C, "R5");
            expect_byte(8'h15, "R5");
        end
        drain();
        cs_high();

        // R6 pair, bit0 = 1
        cs_low();
        send_op(8'h90);
        send_data(8'h00); send_data(8'h00); send_data(8'h01);
        for (int k = 0; k < 3; k++) begin
            expect_byte(8'h15, "R6");
            expect_byte(8'h8C, "R6");
        end
        drain();
        cs_high();

        // R7 status read of reset value
        cs_low();
        send_op(8'h05);
        for (int k = 0; k < 3; k++) expect_byte(8'h00, "R7");
        drain();
        cs_high();

        // R8 WREN then WRSR
        cs_low(); send_op(8'h06); cs_high();
        check(wr_latch, "R8", wr_latch, 1);
        cs_low(); send_op(8'h01); send_data(8'h5A); cs_high();
        check(stat_reg == 8'h5A, "R8", stat_reg, 8'h5A);
        check(!wr_latch, "R8", wr_latch, 0);
        cs_low();
        send_op(8'h05);
        for (int k = 0; k < 4; k++) expect_byte(8'h5A, "R7");
        drain();
        cs_high();

        // R9 WRSR without WREN ignored
        cs_low(); send_op(8'h01); send_data(8'h33); cs_high();
        check(stat_reg == 8'h5A, "R9", stat_reg, 8'h5A);

        // R10 another opcode between WREN and WRSR breaks the pairing
        cs_low(); send_op(8'h06); cs_high();
        check(wr_latch, "R10", wr_latch, 1);
        cs_low(); send_op(8'h9F); cs_high();
        check(!wr_latch, "R10", wr_latch, 0);
        cs_low(); send_op(8'h01); send_data(8'h77); cs_high();
        check(stat_reg == 8'h5A, "R10", stat_reg, 8'h5A);
        cs_low();
        send_op(8'h05);
        expect_byte(8'h5A, "R10");
        drain();
        cs_high();

        // R11 partial byte cut off by deselect, then a fresh opcode
        cs_low();
        for (int i = 0; i < 4; i++) begin
            si = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
        cs_high();
        check(!so_oe, "R11", so_oe, 0);
        cs_low();
        send_op(8'h9F);
        expect_byte(8'h8C, "R11");
        expect_byte(8'h41, "R11");
        expect_byte(8'h16, "R11");
        drain();
        cs_high();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule